// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and watches the destination address of each frame as it arrives, one byte per cycle on which `in_valid` is high. When the sixth address byte has been taken, it classifies the address and reports two flags: whether the frame is to be kept, and whether it failed address matching. The address is classified in a fixed order. An all-ones address is broadcast. Otherwise, if the group bit is set or hashing is forced, the address is looked up in a 64-entry hash table. Otherwise, it is compared exactly with the station address.

A frame that ends before six bytes have been seen gets a decision at once and counts as a miss. In promiscuous mode every frame is kept, but a frame that failed matching still carries the miss flag, so later logic can tell such frames apart. Payload handling and FCS checking belong to other blocks. After a decision the filter ignores the stream until the next start-of-frame marker.

Top module: `rx_da_filter`

## Requirements
- R1: A destination of six 0xFF bytes is broadcast. It is a miss when `cfg_rej_bcast` is 1 and a match when it is 0, whatever the hash table and the station address hold.
- R2: A destination that is not broadcast goes to the hash lookup when bit 0 of its first byte is 1, or when `cfg_hash_all` is 1. Otherwise it goes to the exact compare.
- R3: The hash index is bits 31:26 of the Ethernet CRC-32 over the six destination bytes. The CRC uses the reflected polynomial 0xEDB88320, starts at 0xFFFFFFFF, takes each byte least significant bit first, and is inverted at the end.
- R4: Index bit 5 selects the table word (0 selects `cfg_hash_lo`, 1 selects `cfg_hash_hi`), and index bits 4:0 select the bit within that word. A 1 in that bit is a match and a 0 is a miss.
- R5: The exact compare matches first byte to `cfg_sta_hi[15:8]`, second to `cfg_sta_hi[7:0]`, and third to sixth to `cfg_sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Any difference is a miss.
- R6: If `in_last` comes with a byte before the sixth, the frame is a miss.
- R7: `dec_accept` is 1 for a match. For a miss it is 1 only when `cfg_promisc` is 1, and `dec_miss` stays 1 in that case.
- R8: `dec_valid` is high for one cycle: the cycle after the sixth byte is taken, or the cycle after an early `in_last` byte is taken. `cfg_*` inputs are sampled on the clock edge that takes that byte.
- R9: A frame starts on a byte with `in_first` set, even in the middle of another frame. Bytes after a decision, and bytes with no frame open, produce no decision. Idle cycles inside the address do not change the result.
- R10: After reset, `dec_valid`, `dec_accept` and `dec_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_first | input | 1 | This byte is the first byte of a frame |
| in_last | input | 1 | This byte is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_rej_bcast | input | 1 | Treat broadcast as a miss |
| cfg_hash_all | input | 1 | Send individual addresses to the hash lookup too |
| cfg_promisc | input | 1 | Keep missed frames |
| cfg_sta_hi | input | 16 | Station address, bytes 0 and 1 |
| cfg_sta_lo | input | 32 | Station address, bytes 2 to 5 |
| cfg_hash_lo | input | 32 | Hash table, indices 0 to 31 |
| cfg_hash_hi | input | 32 | Hash table, indices 32 to 63 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Frame failed address matching |

## Verification
Every result is due exactly one clock edge after the byte that settles it. That byte is the sixth address byte, or an `in_last` byte that comes earlier. The bench records the cycle in which it drives that byte, and a monitor samples on the falling edge. This lets each strobe be checked against the drive cycle plus one, and its flags be taken from that same sample. The number of strobes per scenario is counted over a few trailing idle cycles, so a missing strobe, a stretched strobe or an extra strobe is caught.

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  input  logic        cfg_rej_bcast,
  input  logic        cfg_hash_all,
  input  logic        cfg_promisc,
  input  logic [15:0] cfg_sta_hi,
  input  logic [31:0] cfg_sta_lo,
  input  logic [31:0] cfg_hash_lo,
  input  logic [31:0] cfg_hash_hi,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_miss
);
  localparam int AW = ADDR_BYTES * 8;
  localparam int CW = $clog2(ADDR_BYTES + 1);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic          armed;
  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic [AW-1:0] da;

  logic          take;
  logic [CW-1:0] cnt_nx;
  logic [31:0]   crc_nx;
  logic [AW-1:0] da_nx;
  logic          fin, early;
  logic [HASH_BITS-1:0] hidx;
  logic          is_bc, to_hash, hash_hit, uc_hit, miss_full, miss_d;

  assign take   = in_valid && (in_first || armed);
  assign cnt_nx = (in_first ? CW'(0) : cnt) + CW'(1);
  assign crc_nx = crc_step(in_first ? 32'hFFFFFFFF : crc, in_data);
  assign da_nx  = {da[AW-9:0], in_data};
  assign fin    = take && (cnt_nx == CW'(ADDR_BYTES));
  assign early  = take && in_last && (cnt_nx < CW'(ADDR_BYTES));

  assign hidx     = ~crc_nx[31 -: HASH_BITS];
  assign is_bc    = &da_nx;
  assign to_hash  = da_nx[AW-8] || cfg_hash_all;
  assign hash_hit = hidx[5] ? cfg_hash_hi[hidx[4:0]] : cfg_hash_lo[hidx[4:0]];
  assign uc_hit   = (da_nx == {cfg_sta_hi, cfg_sta_lo});
  assign miss_full = is_bc ? cfg_rej_bcast : (to_hash ? !hash_hit : !uc_hit);
  assign miss_d    = early || miss_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      crc   <= 32'hFFFFFFFF;
      da    <= '0;
    end else if (take) begin
      armed <= !(fin || in_last);
      cnt   <= cnt_nx;
      crc   <= crc_nx;
      da    <= da_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end else begin
      dec_valid <= fin || early;
      if (fin || early) begin
        dec_miss   <= miss_d;
        dec_accept <= !miss_d || cfg_promisc;
      end
    end
  end

  // R7
  drop_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_accept |-> dec_miss);

  // R7
  promisc_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin || early) && cfg_promisc |=> dec_valid && dec_accept);

  // R6
  short_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> dec_valid && dec_miss);

  // R9
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_first && !armed |=> !dec_valid);

  // R8
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !dec_valid);
endmodule

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic cfg_rej_bcast = 0, cfg_hash_all = 0, cfg_promisc = 0;
  logic [15:0] cfg_sta_hi = 16'h0211;
  logic [31:0] cfg_sta_lo = 32'h2233_4455;
  logic [31:0] cfg_hash_lo = 0, cfg_hash_hi = 0;
  logic dec_valid, dec_accept, dec_miss;

  rx_da_filter dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, dcyc = 0, pulses = 0, pcyc = 0;
  logic pacc, pmiss;
  bit done = 0;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (dec_valid) begin
    pulses++; pcyc = cyc; pacc = dec_accept; pmiss = dec_miss;
  end

  localparam logic [47:0] STA = 48'h0211_2233_4455;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC  = 48'h0100_5E00_0001;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[j];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    c = ~c;
    return c[31:26];
  endfunction

  task automatic push(input logic [47:0] a, input int n, input bit f, input bit l, input bit gap);
    for (int i = 0; i < n; i++) begin
      if (gap && i == 3) begin @(negedge clk); in_valid = 0; in_first = 0; in_last = 0; end
      @(negedge clk);
      in_valid = 1; in_first = f && (i == 0); in_last = l && (i == n - 1);
      in_data = (i < 6) ? a[47-8*i -: 8] : 8'hA5;
      if (i == 5 || (l && i == n - 1 && n < 6)) dcyc = cyc;
    end
    @(negedge clk); in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic expect_dec(input string tag, input int np, input bit acc, input bit miss);
    repeat (3) @(negedge clk);
    chk(pulses == np, {tag, " strobes"}, pulses, np);
    if (np > 0 && pulses == np) begin
      chk(pcyc == dcyc + 1, {tag, " R8 cycle"}, pcyc, dcyc + 1);
      chk(pacc == acc, {tag, " accept"}, pacc, acc);
      chk(pmiss == miss, {tag, " miss"}, pmiss, miss);
    end
    pulses = 0;
  endtask

  task automatic t_reset;
    chk(dec_valid == 0, "R10 valid", dec_valid, 0);
    chk(dec_accept == 0, "R10 accept", dec_accept, 0);
    chk(dec_miss == 0, "R10 miss", dec_miss, 0);
  endtask

  task automatic t_unicast;
    push(STA, 10, 1, 1, 0);               expect_dec("R5 match", 1, 1, 0);
    push(STA ^ 48'h0000_0001_0000, 6, 1, 1, 1); expect_dec("R5 byte3 diff", 1, 0, 1);
    push(STA ^ 48'h0200_0000_0000, 6, 1, 1, 0); expect_dec("R5 byte0 diff", 1, 0, 1);
    cfg_promisc = 1;
    push(STA ^ 48'h0000_0000_0080, 6, 1, 1, 0); expect_dec("R7 promisc miss", 1, 1, 1);
    cfg_promisc = 0;
  endtask

  task automatic t_broadcast;
    push(BC, 6, 1, 1, 0); expect_dec("R1 bcast ok", 1, 1, 0);
    cfg_rej_bcast = 1;
    push(BC, 6, 1, 1, 0); expect_dec("R1 bcast rej", 1, 0, 1);
    cfg_promisc = 1;
    push(BC, 6, 1, 1, 0); expect_dec("R1 R7 bcast rej promisc", 1, 1, 1);
    cfg_promisc = 0; cfg_rej_bcast = 0;
  endtask

  task automatic t_hash;
    logic [5:0] ix = ref_idx(MC);
    cfg_hash_lo = 0; cfg_hash_hi = 0;
    if (ix[5]) cfg_hash_hi[ix[4:0]] = 1; else cfg_hash_lo[ix[4:0]] = 1;
    push(MC, 6, 1, 1, 0); expect_dec("R3 R4 hash hit", 1, 1, 0);
    cfg_hash_lo = 0; cfg_hash_hi = 0;
    if (ix[5]) cfg_hash_lo[ix[4:0]] = 1; else cfg_hash_hi[ix[4:0]] = 1;
    push(MC, 6, 1, 1, 0); expect_dec("R4 wrong word", 1, 0, 1);
    cfg_hash_lo = 0; cfg_hash_hi = 0;
    if (ix[5]) cfg_hash_hi[~ix[4:0]] = 1; else cfg_hash_lo[~ix[4:0]] = 1;
    push(MC, 6, 1, 1, 0); expect_dec("R4 wrong bit", 1, 0, 1);
    cfg_hash_lo = 0; cfg_hash_hi = 0;
    cfg_hash_all = 1;
    push(STA, 6, 1, 1, 0); expect_dec("R2 hash_all empty", 1, 0, 1);
    ix = ref_idx(STA);
    if (ix[5]) cfg_hash_hi[ix[4:0]] = 1; else cfg_hash_lo[ix[4:0]] = 1;
    push(STA ^ 48'h0000_0000_0100, 6, 1, 1, 0);
    ix = ref_idx(STA ^ 48'h0000_0000_0100);
    if (ix[5]) cfg_hash_hi[ix[4:0]] = 1; else cfg_hash_lo[ix[4:0]] = 1;
    expect_dec("R2 hash_all miss", 1, 0, 1);
    push(STA ^ 48'h0000_0000_0100, 6, 1, 1, 0); expect_dec("R2 R3 hash_all hit", 1, 1, 0);
    cfg_hash_all = 0; cfg_hash_lo = 0; cfg_hash_hi = 0;
  endtask

  task automatic t_short;
    push(STA, 3, 1, 1, 0); expect_dec("R6 three bytes", 1, 0, 1);
    push(BC, 1, 1, 1, 0);  expect_dec("R6 one byte", 1, 0, 1);
    cfg_promisc = 1;
    push(STA, 5, 1, 1, 0); expect_dec("R6 R7 five promisc", 1, 1, 1);
    cfg_promisc = 0;
  endtask

  task automatic t_framing;
    push(STA, 8, 0, 1, 0); expect_dec("R9 no start", 0, 0, 0);
    push(BC, 3, 1, 0, 0);
    push(STA, 6, 1, 1, 0); expect_dec("R9 restart", 1, 1, 0);
    push(STA, 14, 1, 0, 0); expect_dec("R8 R9 trailing", 1, 1, 0);
    push(STA, 6, 0, 1, 0); expect_dec("R9 after decision", 0, 0, 0);
  endtask

  initial begin
    #1 t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_broadcast();
    t_hash();
    t_short();
    t_framing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule